// File: doc/BRIEF.md
# Vectored MCU Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core and turns them into a single vectored request. There are six sources:
- an analog comparator output;
- a group of three external pins that share one flag;
- a fourth external pin;
- a PWM period strobe;
- two timer overflow strobes.

Pin inputs pass through edge detectors. Each pin has its own fixed trigger polarity. Strobe inputs set their flag in any cycle they are high.

The enable bits, request flags and a global enable live in two 8-bit control registers. The core reads and writes these registers through a simple select/data port. When the global enable is set and the core reports that its return stack has room, the block presents the pending, enabled request with the lowest vector address. It drives that request's fixed vector on `irq_vec_o` together with `irq_req_o`.

A one-cycle `irq_ack_i` from the core accepts the interrupt. Acceptance clears the winning flag and the global enable, so nesting stays off unless the service routine sets the global enable again. Every flag-set event also produces a one-cycle wake pulse. The pulse does not depend on the enables.

Top module: `mcu_intc`

## Requirements
- R1: After reset:
  - both control registers read 0x00;
  - `irq_req_o` and `wake_o` are 0.
  
  Pins held at their idle level through reset (comparator, INT0A and INT1 high; INT0B and INT0C low) set no flag after reset is released.
- R2: Register 0 (`rd_sel_i`/`wr_sel_i` = 0) has this layout:
  - bit0 global enable;
  - bit1 comparator enable;
  - bit2 INT0-group enable;
  - bit3 INT1 enable;
  - bit4 comparator flag;
  - bit5 INT0-group flag;
  - bit6 INT1 flag.
  
  Bits 0..6 are written from `wr_data_i[6:0]`. Bit 7 reads 0.
- R3: Register 1 (select = 1) has this layout:
  - bit1 PWM enable;
  - bit2 timer 0 enable;
  - bit3 timer 1 enable;
  - bit4 PWM flag;
  - bit5 timer 0 flag;
  - bit6 timer 1 flag.
  
  Bits 0 and 7 read 0. Writing `wr_data_i[0]` with select = 1 leaves the global enable unchanged.
- R4: The pins set their flags on these edges:
  - the comparator flag on a falling edge of `cmp_i`;
  - the INT0-group flag on a falling edge of `int0a_i` or a rising edge of `int0b_i` or `int0c_i`;
  - the INT1 flag on a falling edge of `int1_i`.
  
  The flag reads as set after the clock edge that samples the new pin level. The opposite edge sets nothing.
- R5: `pwm_tick_i`, `tmr0_ovf_i` and `tmr1_ovf_i` each set their flag when sampled high at a clock edge.
- R6: `irq_req_o` is 1 exactly when all of these hold:
  - the global enable is 1;
  - `stack_full_i` is 0;
  - some source has both its flag and its enable set.
  
  The vectors are comparator 0x04, INT0 group 0x08, INT1 0x0C, PWM 0x10, timer 0 0x14 and timer 1 0x18.
- R7: When several sources are eligible, `irq_vec_o` carries the lowest vector.
- R8: At the clock edge where `irq_ack_i` and `irq_req_o` are both 1, two things are cleared:
  - the flag of the presented source;
  - the global enable.
  
  All other flags and enables keep their values.
- R9: While `stack_full_i` is 1, `irq_req_o` is 0. Pending flags stay set until the request is accepted.
- R10: Flags are set regardless of the global enable and of their own enable bit.
- R11: Priority between events that hit the same bit in the same cycle:
  - a hardware flag-set event beats a software write of 0 to that flag;
  - acceptance beats a software write to the accepted flag and to the global enable.
- R12: `wake_o` pulses high for one cycle, in the cycle after any flag-set event, whatever the enables.
- R13: `irq_ack_i` while `irq_req_o` is 0 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 = register 0, 1 = register 1 |
| wr_data_i | input | 7 | Write data for bits 6..0 |
| rd_sel_i | input | 1 | Read select |
| rd_data_o | output | 8 | Selected register contents |
| cmp_i | input | 1 | Comparator output |
| int0a_i | input | 1 | External pin A of group 0 (falling edge) |
| int0b_i | input | 1 | External pin B of group 0 (rising edge) |
| int0c_i | input | 1 | External pin C of group 0 (rising edge) |
| int1_i | input | 1 | External pin 1 (falling edge) |
| pwm_tick_i | input | 1 | PWM period strobe |
| tmr0_ovf_i | input | 1 | Timer 0 overflow strobe |
| tmr1_ovf_i | input | 1 | Timer 1 overflow strobe |
| stack_full_i | input | 1 | Core return stack is full |
| irq_ack_i | input | 1 | Core accepts the presented interrupt |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 8 | Vector address of the presented request |
| wake_o | output | 1 | Wake-up pulse on any flag-set event |

## Verification
The request and vector outputs are combinational functions of the flag, enable and global-enable registers. A corrupted flag or enable therefore shows up on `irq_vec_o`/`irq_req_o` in the same cycle, or on a readback one cycle after the event that corrupted it. A wrong edge-detector history shows up on the cycle after the first pin transition, as a missing flag or a spurious one, and as a missing or extra `wake_o` pulse. The sweeps cover all 64 flag patterns under full enables and all 64 enable patterns under full flags. Each pattern is checked for the request, the vector and the exact register contents after acceptance. Acceptance attempts are made with the stack full and the request low.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_SRC  = 6;
  localparam int PER_BANK = 3;
  localparam int DATA_W   = 8;
  localparam int VEC_W    = 8;
  localparam int VEC_STEP = 4;
  localparam int EN_LSB   = 1;
  localparam int FLAG_LSB = 4;
  localparam int NUM_PIN  = 5;

  typedef enum logic [2:0] {
    SRC_CMP  = 3'd0,
    SRC_INT0 = 3'd1,
    SRC_INT1 = 3'd2,
    SRC_PWM  = 3'd3,
    SRC_TMR0 = 3'd4,
    SRC_TMR1 = 3'd5
  } src_e;

  function automatic logic [VEC_W-1:0] vec_of(input int idx);
    return VEC_W'((idx + 1) * VEC_STEP);
  endfunction
endpackage

// File: rtl/intc_edge.sv
module intc_edge #(
  parameter bit FALL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic edge_o
);
  logic prev_q;

  // history starts at the level that cannot produce the active edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= ~FALL;
    else         prev_q <= sig_i;
  end

  if (FALL) begin : g_fall
    assign edge_o = prev_q & ~sig_i;
  end else begin : g_rise
    assign edge_o = ~prev_q & sig_i;
  end
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int N_SRC   = NUM_SRC,
  parameter int N_BANK_SRC = PER_BANK,
  parameter int D_W     = DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [D_W-2:0]   wr_data_i,
  input  logic [N_SRC-1:0] set_i,
  input  logic             ack_i,
  input  logic [N_SRC-1:0] grant_i,
  output logic             gie_o,
  output logic [N_SRC-1:0] en_o,
  output logic [N_SRC-1:0] flag_o,
  output logic [D_W-1:0]   ctrl0_o,
  output logic [D_W-1:0]   ctrl1_o
);
  localparam int N_BANK = (N_SRC + N_BANK_SRC - 1) / N_BANK_SRC;

  logic             gie_q;
  logic [N_SRC-1:0] en_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        gie_q <= 1'b0;
    else if (ack_i)                     gie_q <= 1'b0;
    else if (wr_en_i && !wr_sel_i)      gie_q <= wr_data_i[0];
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    localparam int B = i / N_BANK_SRC;
    localparam int P = i % N_BANK_SRC;
    logic wr_hit;
    assign wr_hit = wr_en_i && (wr_sel_i == 1'(B));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    flag_q[i] <= 1'b0;
      else if (set_i[i])              flag_q[i] <= 1'b1;
      else if (ack_i && grant_i[i])   flag_q[i] <= 1'b0;
      else if (wr_hit)                flag_q[i] <= wr_data_i[FLAG_LSB+P];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     en_q[i] <= 1'b0;
      else if (wr_hit) en_q[i] <= wr_data_i[EN_LSB+P];
    end

    assert_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_q[i]);
    assert_ack_clears_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && grant_i[i] && !set_i[i]) |=> !flag_q[i]);
  end

  logic [D_W-1:0] bank [N_BANK];
  always_comb begin
    for (int b = 0; b < N_BANK; b++) bank[b] = '0;
    bank[0][0] = gie_q;
    for (int i = 0; i < N_SRC; i++) begin
      bank[i / N_BANK_SRC][EN_LSB + (i % N_BANK_SRC)]   = en_q[i];
      bank[i / N_BANK_SRC][FLAG_LSB + (i % N_BANK_SRC)] = flag_q[i];
    end
  end

  assign ctrl0_o = bank[0];
  assign ctrl1_o = bank[N_BANK-1];
  assign gie_o   = gie_q;
  assign en_o    = en_q;
  assign flag_o  = flag_q;

  assert_ack_clears_gie_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !gie_q);
endmodule

// File: rtl/intc_arb.sv
module intc_arb
  import intc_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int V_W   = VEC_W
) (
  input  logic [N_SRC-1:0] pend_i,
  output logic             any_o,
  output logic [N_SRC-1:0] grant_o,
  output logic [V_W-1:0]   vec_o
);
  localparam int IDX_W = $clog2(N_SRC);

  logic [IDX_W-1:0] idx;

  always_comb begin
    idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (pend_i[i]) idx = IDX_W'(i);
  end

  assign any_o = |pend_i;

  always_comb begin
    grant_o      = '0;
    grant_o[idx] = any_o;
  end

  assign vec_o = V_W'((int'(idx) + 1) * VEC_STEP);

  always_comb begin
    if (any_o) begin
      assert_lowest_wins_R7: assert ($onehot(grant_o) && ((pend_i & grant_o) != '0)
        && ((pend_i & (grant_o - 1'b1)) == '0));
    end
  end
endmodule

// File: rtl/mcu_intc.sv
module mcu_intc
  import intc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       wr_sel_i,
  input  logic [6:0] wr_data_i,
  input  logic       rd_sel_i,
  output logic [7:0] rd_data_o,
  input  logic       cmp_i,
  input  logic       int0a_i,
  input  logic       int0b_i,
  input  logic       int0c_i,
  input  logic       int1_i,
  input  logic       pwm_tick_i,
  input  logic       tmr0_ovf_i,
  input  logic       tmr1_ovf_i,
  input  logic       stack_full_i,
  input  logic       irq_ack_i,
  output logic       irq_req_o,
  output logic [7:0] irq_vec_o,
  output logic       wake_o
);
  // pin order: cmp, int0a, int0b, int0c, int1
  localparam logic [NUM_PIN-1:0] EDGE_FALL = 5'b10011;

  logic [NUM_PIN-1:0] pins, pin_edge;
  logic [NUM_SRC-1:0] set_evt, en, flag, grant;
  logic               gie, any_pend, ack_fire, wake_q;
  logic [DATA_W-1:0]  ctrl0, ctrl1;

  assign pins = {int1_i, int0c_i, int0b_i, int0a_i, cmp_i};

  for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
    intc_edge #(.FALL(EDGE_FALL[p])) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sig_i  (pins[p]),
      .edge_o (pin_edge[p])
    );
  end

  assign set_evt[SRC_CMP]  = pin_edge[0];
  assign set_evt[SRC_INT0] = |pin_edge[3:1];
  assign set_evt[SRC_INT1] = pin_edge[4];
  assign set_evt[SRC_PWM]  = pwm_tick_i;
  assign set_evt[SRC_TMR0] = tmr0_ovf_i;
  assign set_evt[SRC_TMR1] = tmr1_ovf_i;

  intc_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .set_i     (set_evt),
    .ack_i     (ack_fire),
    .grant_i   (grant),
    .gie_o     (gie),
    .en_o      (en),
    .flag_o    (flag),
    .ctrl0_o   (ctrl0),
    .ctrl1_o   (ctrl1)
  );

  intc_arb u_arb (
    .pend_i  (flag & en),
    .any_o   (any_pend),
    .grant_o (grant),
    .vec_o   (irq_vec_o)
  );

  assign irq_req_o = gie && !stack_full_i && any_pend;
  assign ack_fire  = irq_ack_i && irq_req_o;
  assign rd_data_o = rd_sel_i ? ctrl1 : ctrl0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_q <= 1'b0;
    else         wake_q <= |set_evt;
  end
  assign wake_o = wake_q;

  assert_stack_full_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_full_i |-> !irq_req_o);
  assert_wake_follows_set_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_evt) |=> wake_o);
  assert_wake_one_shot_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|set_evt) |=> !wake_o);
  assert_req_needs_gie_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (ctrl0[0] && ((flag & en) != '0)));
endmodule

// File: tb/mcu_intc_tb.sv
module mcu_intc_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [6:0] wr_data = '0;
  logic [7:0] rd_data, irq_vec;
  logic       cmp = 1'b1, i0a = 1'b1, i0b = 1'b0, i0c = 1'b0, i1 = 1'b1;
  logic       pwm = 1'b0, t0 = 1'b0, t1 = 1'b0;
  logic       stk_full = 1'b0, ack = 1'b0;
  logic       irq_req, wake;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  mcu_intc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .cmp_i(cmp), .int0a_i(i0a), .int0b_i(i0b), .int0c_i(i0c), .int1_i(i1),
    .pwm_tick_i(pwm), .tmr0_ovf_i(t0), .tmr1_ovf_i(t1),
    .stack_full_i(stk_full), .irq_ack_i(ack), .irq_req_o(irq_req),
    .irq_vec_o(irq_vec), .wake_o(wake)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rdchk(input string req, input logic sel, input logic [7:0] exp);
    rd_sel = sel;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic wr(input logic sel, input logic [6:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  // drive one pin to its active level and check the flag bit and wake pulse
  task automatic pin_test(input int p, input logic sel, input int bitpos);
    case (p)
      0: cmp = 1'b0; 1: i0a = 1'b0; 2: i0b = 1'b1; 3: i0c = 1'b1; default: i1 = 1'b0;
    endcase
    @(negedge clk);
    chk("R12 wake on pin edge", 8'(wake), 8'h01);
    rdchk("R4 pin edge sets flag", sel, 8'(1 << bitpos));
    case (p)
      0: cmp = 1'b1; 1: i0a = 1'b1; 2: i0b = 1'b0; 3: i0c = 1'b0; default: i1 = 1'b1;
    endcase
    @(negedge clk);
    chk("R4 opposite edge no wake", 8'(wake), 8'h00);
    wr(sel, '0);
    rdchk("R4 flag cleared by write", sel, 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state, idle pins set nothing
    rdchk("R1 reg0 reset", 1'b0, 8'h00);
    rdchk("R1 reg1 reset", 1'b1, 8'h00);
    chk("R1 irq_req reset", 8'(irq_req), 8'h00);
    chk("R1 wake reset", 8'(wake), 8'h00);

    // R2/R3 layout and unused bits
    wr(1'b0, 7'h7f);
    rdchk("R2 reg0 all ones", 1'b0, 8'h7f);
    wr(1'b1, 7'h7f);
    rdchk("R3 reg1 bits 0 and 7 zero", 1'b1, 8'h7e);
    wr(1'b1, 7'h01);
    rdchk("R3 reg1 bit0 write keeps gie", 1'b0, 8'h7f);
    wr(1'b0, 7'h00);
    wr(1'b1, 7'h00);
    rdchk("R2 reg0 cleared", 1'b0, 8'h00);

    // R4/R10 pin edges, all enables off and gie off
    pin_test(0, 1'b0, 4);
    pin_test(1, 1'b0, 5);
    pin_test(2, 1'b0, 5);
    pin_test(3, 1'b0, 5);
    pin_test(4, 1'b0, 6);

    // R5 strobes
    for (int s = 0; s < 3; s++) begin
      pwm = (s == 0); t0 = (s == 1); t1 = (s == 2);
      @(negedge clk);
      pwm = 1'b0; t0 = 1'b0; t1 = 1'b0;
      chk("R12 wake on strobe", 8'(wake), 8'h01);
      rdchk("R5 strobe sets flag", 1'b1, 8'(1 << (4 + s)));
      chk("R10 no request with gie off", 8'(irq_req), 8'h00);
      wr(1'b1, '0);
    end

    // R6/R7/R8/R9/R13 sweep over all flag patterns, full enables
    for (int f = 0; f < 64; f++) begin
      int w;
      logic [7:0] e0, e1;
      w  = f & -f;
      e0 = {1'b0, 3'(f), 3'b111, 1'b1};
      e1 = {1'b0, 3'(f >> 3), 3'b111, 1'b0};
      wr(1'b0, e0[6:0]);
      wr(1'b1, e1[6:0]);
      chk("R6 request", 8'(irq_req), 8'(f != 0));
      if (f != 0) chk("R7 lowest vector", irq_vec, 8'(($clog2(w) + 1) * 4));
      stk_full = 1'b1;
      #1;
      chk("R9 stack full blocks", 8'(irq_req), 8'h00);
      pulse_ack();
      stk_full = 1'b0;
      rdchk("R13 ack ignored reg0", 1'b0, e0);
      rdchk("R9 flags held reg1", 1'b1, e1);
      pulse_ack();
      if (f != 0) begin
        e0 = {1'b0, 3'(f & ~w), 3'b111, 1'b0};
        e1 = {1'b0, 3'((f & ~w) >> 3), 3'b111, 1'b0};
      end
      rdchk("R8 reg0 after accept", 1'b0, e0);
      rdchk("R8 reg1 after accept", 1'b1, e1);
      chk("R6 no request after gie clear", 8'(irq_req), 8'(f == 0 && 1'b0));
    end

    // R6/R7 sweep over enable patterns, all flags set
    for (int e = 0; e < 64; e++) begin
      int w;
      w = e & -e;
      wr(1'b0, {3'b111, 3'(e), 1'b1});
      wr(1'b1, {3'b111, 3'(e >> 3), 1'b0});
      chk("R6 enable gating", 8'(irq_req), 8'(e != 0));
      if (e != 0) chk("R7 vector by enable", irq_vec, 8'(($clog2(w) + 1) * 4));
    end
    wr(1'b0, '0);
    wr(1'b1, '0);

    // R11 hardware set beats software clear
    wr(1'b0, 7'h10);
    cmp = 1'b0;
    wr(1'b0, 7'h00);
    rdchk("R11 set beats write", 1'b0, 8'h10);
    cmp = 1'b1;
    @(negedge clk);
    // R11 accept beats software write
    wr(1'b0, 7'h13);
    chk("R6 comparator vector", irq_vec, 8'h04);
    ack = 1'b1;
    wr(1'b0, 7'h13);
    ack = 1'b0;
    rdchk("R11 accept beats write", 1'b0, 8'h02);
    chk("R12 no spurious wake", 8'(wake), 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule